// File: doc/BRIEF.md
# Serial Control Register Bank (block-transfer two-wire slave)

This block is a two-wire serial slave that holds a nine-byte control bank for a clock-control datapath. Both bus lines are oversampled by a fast system clock. The block recognises one fixed 7-bit device address and handles start, stop, acknowledge and byte sequencing. It accepts block writes and serves block reads, and it drives the data line only through a pull-low enable. The register contents are presented in parallel to the neighbouring control logic.

A write transfer carries the address byte, then a command byte and a length byte, then the data. The command and length bytes are acknowledged and thrown away. Data always lands in register 0 first and then in each following register in turn. A read transfer first returns the fixed length value and then the registers from index 0 upward, until the master declines a byte. The straps sampled during reset are held in a status register that software can read, and their bits read back inverted.

Top module: `ser_ctl_bank`

## Requirements
- R1: The device address is 7'b1101001, so address byte 0xD2 is a write and 0xD3 is a read. Both are acknowledged (SDA pulled low during the ninth clock). Any other address byte gets no acknowledge, and the bank is left unchanged.
- R2: On a write, the two bytes after the address are acknowledged and discarded. The data bytes after them go to registers 0, 1, 2 and onward in order, and every data byte is acknowledged.
- R3: On a read, the first byte returned is the length value 0x09. It is followed by register 0, register 1 and so on in ascending order.
- R4: Bytes move most significant bit first. The slave changes its SDA drive only after a detected SCL falling edge, or after a start or stop.
- R5: After reset the bank holds: reg0 = 0x42, reg1 to reg4 = 0xFF, reg6 = 0x03, reg7 = 0x00, reg8 = 0x02.
- R6: Reg5 reads back as {~fs[3:0], 1, ~sel, en[1:0]}. Here fs and sel are the strap inputs captured while rst is high, and en resets to 2'b11. Only bits 1:0 are writable, and strap changes after reset have no effect.
- R7: Writes to reg6 and reg8 have no effect. Data bytes beyond reg8 are acknowledged and discarded.
- R8: When the master does not acknowledge a read byte, the slave stops driving SDA. It stays released for any further clocks until the next start.
- R9: A start or stop at any point returns the slave to waiting for an address. Registers written earlier keep their values, and a partly received byte is not written.
- R10: Output cfg_bytes carries register i on bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus value) |
| sda_drive_low | output | 1 | When high, the pad pulls SDA low |
| strap_fs | input | 4 | Frequency-select straps, captured during reset |
| strap_sel | input | 1 | Output-rate select strap, captured during reset |
| cfg_bytes | output | NUM_REGS*8 | Parallel view of the register bank |

## Verification
A wrong byte or bit counter shows up on the very next acknowledge slot: the slave either fails to pull SDA low or pulls it one clock late. A register write aimed at the wrong slot changes cfg_bytes at the falling SCL edge that ends the eighth bit, so the fault is visible before the transfer finishes. A read pointer that does not restart at the length byte corrupts the first byte returned. A slave that does not let go after a master NACK holds SDA low on the next clock, where the bus model sees it as a stuck-low line.

// File: rtl/ctlbank_pkg.sv
package ctlbank_pkg;

    localparam int REG_COUNT = 9;
    localparam int REG_IDX_W = $clog2(REG_COUNT);
    localparam int STRAP_REG = 5;
    localparam int REV_REG   = 6;
    localparam int DEVID_REG = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RECV,
        PH_RECV_END,
        PH_ACK_OUT,
        PH_SEND,
        PH_ACK_IN
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic                 en;
        logic [REG_IDX_W-1:0] idx;
        logic [7:0]           data;
    } reg_wr_t;

    function automatic logic [7:0] reset_byte(input int idx);
        case (idx)
            0:          return 8'h42;
            1, 2, 3, 4: return 8'hFF;
            5:          return 8'h03;
            6:          return 8'h03;
            8:          return 8'h02;
            default:    return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] write_mask(input int idx);
        case (idx)
            STRAP_REG:          return 8'h03;
            REV_REG, DEVID_REG: return 8'h00;
            default:            return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/ctl_line_sync.sv
module ctl_line_sync
    import ctlbank_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import ctlbank_pkg::*;
#(
    parameter int NUM_REGS = REG_COUNT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [3:0]            strap_fs,
    input  logic                  strap_sel,
    input  reg_wr_t               wr,
    input  logic [REG_IDX_W-1:0]  rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] bank_flat
);
    logic [7:0] regs [NUM_REGS];
    logic [7:0] view [NUM_REGS];
    logic [3:0] fs_lat;
    logic       sel_lat;
    logic [7:0] wmask;

    assign wmask = write_mask(int'(wr.idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_lat  <= strap_fs;
            sel_lat <= strap_sel;
            for (int i = 0; i < NUM_REGS; i++) begin
                regs[i] <= reset_byte(i);
            end
        end else if (wr.en) begin
            regs[wr.idx] <= (regs[wr.idx] & ~wmask) | (wr.data & wmask);
        end
    end

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_view
        if (gi == STRAP_REG) begin : g_strap
            assign view[gi] = {~fs_lat, 1'b1, ~sel_lat, regs[gi][1:0]};
        end else begin : g_plain
            assign view[gi] = regs[gi];
        end
        assign bank_flat[gi*8 +: 8] = view[gi];
    end

    assign rd_data = (int'(rd_idx) < NUM_REGS) ? view[rd_idx] : 8'h00;
endmodule

// File: rtl/ctl_serial_fsm.sv
module ctl_serial_fsm
    import ctlbank_pkg::*;
#(
    parameter int         NUM_REGS = REG_COUNT,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_ev_t              ev,
    input  logic [7:0]           rd_data,
    output logic [REG_IDX_W-1:0] rd_idx,
    output reg_wr_t              wr_req,
    output logic                 sda_low
);
    localparam int         CNT_W     = $clog2(NUM_REGS + 3);
    localparam logic [7:0] BLOCK_LEN = 8'(NUM_REGS);
    localparam int         WR_LAST   = NUM_REGS + 2;
    localparam int         RD_LAST   = NUM_REGS + 1;

    phase_e           phase;
    logic [7:0]       shreg;
    logic [2:0]       bitcnt;
    logic             is_addr;
    logic             rd_mode;
    logic             nack;
    logic [CNT_W-1:0] wcnt;
    logic [CNT_W-1:0] rd_ptr;
    logic [7:0]       tx_byte;

    assign rd_idx  = REG_IDX_W'(rd_ptr - CNT_W'(1));
    assign tx_byte = (rd_ptr == '0) ? BLOCK_LEN : rd_data;
    assign sda_low = (phase == PH_ACK_OUT) || ((phase == PH_SEND) && !shreg[7]);

    always_ff @(posedge clk) begin
        wr_req.en <= 1'b0;
        if (rst) begin
            phase       <= PH_IDLE;
            shreg       <= '0;
            bitcnt      <= '0;
            is_addr     <= 1'b0;
            rd_mode     <= 1'b0;
            nack        <= 1'b1;
            wcnt        <= '0;
            rd_ptr      <= '0;
            wr_req.idx  <= '0;
            wr_req.data <= '0;
        end else if (ev.start) begin
            phase   <= PH_RECV;
            bitcnt  <= '0;
            is_addr <= 1'b1;
        end else if (ev.stop) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_RECV: if (ev.rise) begin
                    shreg  <= {shreg[6:0], ev.sda};
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) phase <= PH_RECV_END;
                end
                PH_RECV_END: if (ev.fall) begin
                    if (is_addr) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                            phase   <= PH_ACK_OUT;
                            rd_mode <= shreg[0];
                            wcnt    <= '0;
                            rd_ptr  <= '0;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end else begin
                        phase <= PH_ACK_OUT;
                        if (int'(wcnt) >= 2 && int'(wcnt) < WR_LAST) begin
                            wr_req.en   <= 1'b1;
                            wr_req.idx  <= REG_IDX_W'(wcnt - CNT_W'(2));
                            wr_req.data <= shreg;
                        end
                        if (int'(wcnt) != WR_LAST) wcnt <= wcnt + CNT_W'(1);
                    end
                end
                PH_ACK_OUT: if (ev.fall) begin
                    is_addr <= 1'b0;
                    bitcnt  <= '0;
                    if (rd_mode) begin
                        phase <= PH_SEND;
                        shreg <= tx_byte;
                        if (int'(rd_ptr) != RD_LAST) rd_ptr <= rd_ptr + CNT_W'(1);
                    end else begin
                        phase <= PH_RECV;
                    end
                end
                PH_SEND: if (ev.fall) begin
                    if (bitcnt == 3'd7) begin
                        phase <= PH_ACK_IN;
                    end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        bitcnt <= bitcnt + 3'd1;
                    end
                end
                PH_ACK_IN: begin
                    if (ev.rise) nack <= ev.sda;
                    if (ev.fall) begin
                        if (!nack) begin
                            phase  <= PH_SEND;
                            shreg  <= tx_byte;
                            bitcnt <= '0;
                            if (int'(rd_ptr) != RD_LAST) rd_ptr <= rd_ptr + CNT_W'(1);
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ser_ctl_bank.sv
module ser_ctl_bank
    import ctlbank_pkg::*;
#(
    parameter int         NUM_REGS    = REG_COUNT,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_drive_low,
    input  logic [3:0]            strap_fs,
    input  logic                  strap_sel,
    output logic [NUM_REGS*8-1:0] cfg_bytes
);
    bus_ev_t              bus_ev;
    reg_wr_t              wr_req;
    logic [REG_IDX_W-1:0] rd_idx;
    logic [7:0]           rd_data;

    ctl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (bus_ev)
    );

    ctl_serial_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (bus_ev),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .wr_req  (wr_req),
        .sda_low (sda_drive_low)
    );

    ctl_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .strap_fs  (strap_fs),
        .strap_sel (strap_sel),
        .wr        (wr_req),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .bank_flat (cfg_bytes)
    );
endmodule

// File: rtl/ser_ctl_bank_chk.sv
module ser_ctl_bank_chk
    import ctlbank_pkg::*;
#(
    parameter int NUM_REGS = REG_COUNT
) (
    input logic                  clk,
    input logic                  rst,
    input bus_ev_t               ev,
    input logic                  sda_drive_low,
    input logic [NUM_REGS*8-1:0] cfg_bytes
);
    // R4
    sda_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_drive_low) |-> $past(ev.fall || ev.start || ev.stop));

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_drive_low);

    // R9
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !sda_drive_low);

    if (NUM_REGS > DEVID_REG) begin : g_ro
        // R7
        ro_id_chk: assert property (@(posedge clk) disable iff (rst)
            $stable(cfg_bytes[REV_REG*8 +: 8]) && $stable(cfg_bytes[DEVID_REG*8 +: 8]));

        // R6
        strap_field_chk: assert property (@(posedge clk) disable iff (rst)
            $stable(cfg_bytes[STRAP_REG*8+2 +: 6]));
    end
endmodule

bind ser_ctl_bank ser_ctl_bank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ev            (bus_ev),
    .sda_drive_low (sda_drive_low),
    .cfg_bytes     (cfg_bytes)
);

// File: tb/test_ser_ctl_bank.sv
module test_ser_ctl_bank;
    localparam int NREG = 9;
    localparam int Q    = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            scl_m = 1'b1;
    logic            sda_m = 1'b1;
    logic [3:0]      strap_fs = 4'b1010;
    logic            strap_sel = 1'b1;
    logic            sda_low;
    logic [NREG*8-1:0] cfg;
    wire             sda_line = sda_m & ~sda_low;

    logic [7:0] model [NREG];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ser_ctl_bank i_ser_ctl_bank (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .sda_drive_low (sda_low),
        .strap_fs      (strap_fs),
        .strap_sel     (strap_sel),
        .cfg_bytes     (cfg)
    );

    task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [71:0] exp_flat();
        logic [71:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    function automatic void apply_write(input int idx, input logic [7:0] v);
        if (idx == 5) model[5][1:0] = v[1:0];
        else if (idx < NREG && idx != 6 && idx != 8) model[idx] = v;
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic s);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        s = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) xbit(b[i], s);
        xbit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] b);
        logic s;
        for (int i = 0; i < 8; i++) begin
            xbit(1'b1, s);
            b = {b[6:0], s};
        end
        xbit(last, s);
    endtask

    task automatic write_txn(input logic [7:0] addr, input logic [7:0] cmd, input logic [7:0] cnt,
                             input int n, input logic [7:0] d [16]);
        logic ack;
        bool_ok: begin end
        bus_start();
        send_byte(addr, ack);
        if (addr == 8'hD2) begin
            chk(ack, "R1 write address ack", 72'(ack), 72'(1));
            send_byte(cmd, ack);
            chk(ack, "R2 command byte ack", 72'(ack), 72'(1));
            send_byte(cnt, ack);
            chk(ack, "R2 length byte ack", 72'(ack), 72'(1));
            for (int k = 0; k < n; k++) begin
                send_byte(d[k], ack);
                chk(ack, (k < NREG) ? "R2 data byte ack" : "R7 surplus byte ack", 72'(ack), 72'(1));
                apply_write(k, d[k]);
            end
        end else begin
            chk(!ack, "R1 foreign address not acked", 72'(ack), 72'(0));
        end
        bus_stop();
        chk(cfg == exp_flat(), "R2 R7 R10 bank after write", cfg, exp_flat());
    endtask

    task automatic read_txn(input int n);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, ack);
        chk(ack, "R1 read address ack", 72'(ack), 72'(1));
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, b);
            if (k == 0) chk(b == 8'h09, "R3 length byte first", 72'(b), 72'h09);
            else chk(b == model[k-1], "R3 R4 register readback", 72'(b), 72'(model[k-1]));
        end
        bus_stop();
    endtask

    initial begin
        logic [7:0] d [16];
        logic ack;
        logic s;
        logic [7:0] b;
        void'($urandom(32'd24680));
        model[0] = 8'h42; model[1] = 8'hFF; model[2] = 8'hFF; model[3] = 8'hFF;
        model[4] = 8'hFF; model[5] = 8'h5B; model[6] = 8'h03; model[7] = 8'h00;
        model[8] = 8'h02;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        strap_fs  = 4'b0101;
        strap_sel = 1'b0;
        @(negedge clk);
        // R5 R6 R10: reset contents and layout, straps latched during reset only
        chk(cfg == exp_flat(), "R5 R6 R10 reset bank", cfg, exp_flat());
        chk(sda_low == 1'b0, "R5 idle release", 72'(sda_low), 72'(0));

        // R3 R4: full read of length byte plus all registers
        read_txn(NREG + 1);

        // R2: short directed write
        d[0] = 8'hA5; d[1] = 8'h3C; d[2] = 8'h81;
        write_txn(8'hD2, 8'h00, 8'h09, 3, d);

        // R1: foreign address leaves bank alone
        write_txn(8'hA4, 8'h00, 8'h00, 0, d);

        // R6 R7: write through every slot and beyond the end
        for (int k = 0; k < 11; k++) d[k] = 8'hC0 + 8'(k);
        d[5] = 8'h00; d[6] = 8'hEE; d[8] = 8'hDD;
        write_txn(8'hD2, 8'h55, 8'h0B, 11, d);
        read_txn(NREG + 1);

        // R8: NACK after two bytes, then slave stays off the line
        bus_start();
        send_byte(8'hD3, ack);
        recv_byte(1'b0, b);
        chk(b == 8'h09, "R8 length before nack", 72'(b), 72'h09);
        recv_byte(1'b1, b);
        chk(b == model[0], "R8 reg0 before nack", 72'(b), 72'(model[0]));
        for (int k = 0; k < 9; k++) begin
            xbit(1'b1, s);
            chk(s == 1'b1, "R8 released after nack", 72'(s), 72'(1));
        end
        bus_stop();

        // R9: repeated start in the middle of a data byte
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack);
        send_byte(8'h09, ack);
        send_byte(8'h11, ack);
        apply_write(0, 8'h11);
        for (int i = 0; i < 4; i++) xbit(1'b0, s);
        bus_start();
        send_byte(8'hD3, ack);
        chk(ack, "R9 address after repeated start", 72'(ack), 72'(1));
        recv_byte(1'b0, b);
        chk(b == 8'h09, "R9 length after repeated start", 72'(b), 72'h09);
        recv_byte(1'b0, b);
        chk(b == 8'h11, "R9 reg0 kept", 72'(b), 72'h11);
        recv_byte(1'b1, b);
        chk(b == model[1], "R9 reg1 untouched by partial byte", 72'(b), 72'(model[1]));
        bus_stop();

        // R9: stop in the middle of a data byte
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack);
        send_byte(8'h09, ack);
        for (int i = 0; i < 4; i++) xbit(1'b0, s);
        bus_stop();
        chk(cfg == exp_flat(), "R9 bank after mid-byte stop", cfg, exp_flat());

        // Random block writes, some to foreign addresses, with periodic readback
        for (int t = 0; t < 14; t++) begin
            logic [7:0] a;
            int n;
            n = int'($urandom_range(1, 11));
            for (int k = 0; k < 16; k++) d[k] = 8'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                a = 8'($urandom);
                if (a[7:1] == 7'h69) a = a ^ 8'h80;
            end else begin
                a = 8'hD2;
            end
            write_txn(a, 8'($urandom), 8'($urandom), n, d);
            if (t % 4 == 3) read_txn(NREG + 1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule